// File: doc/BRIEF.md
# Interrupt Pending and Mask Controller

This block collects requests from 32 interrupt sources and holds each one in a source-pending register until software clears it. A mask register gates which sources may be serviced. A mode register sends each source either to the fast interrupt output or to the normal interrupt output. At most one source may use the fast path.

For the normal path, the block keeps a one-hot winner register and an offset register. The winner register is loaded with the lowest-index unmasked normal-mode pending source, and only when it is empty. The offset register reports the binary index of that winner. Software services the interrupt by clearing the source-pending bit first and then the winner bit. The offset then returns to zero on its own.

A sub-source stage lets two sub-requests share one parent source bit. Each sub-request has its own pending bit and its own sub-mask bit. All registers sit behind a simple word-addressed write strobe and a combinational read port.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A source-pending bit (address 0) becomes 1 on the clock edge that samples its request input high. This happens even when the source is masked, and the bit stays 1 after the request drops.
- R2: Writing to a pending register (addresses 0, 3 and 5) clears each bit written as 1 and leaves each bit written as 0 unchanged. A request sampled in the same cycle as the clear keeps the bit at 1.
- R3: Mode register (address 1): bit value 1 routes the source to the fast output and 0 routes it to the normal path. A write whose data has more than one bit set is ignored.
- R4: Mask register (address 2): bit value 1 blocks the source. A masked pending source never drives the fast output and is never captured into the winner register.
- R5: fiq_o is high exactly when some source is pending, unmasked and in mode 1.
- R6: The winner register (address 3) is one-hot. While it is zero, it loads the lowest-index pending, unmasked, mode-0 source. While it is nonzero, it changes only through software clears. irq_o is high while it is nonzero.
- R7: Offset register (address 4) reads the index of the winner bit. Once the winner register is empty and the source-pending bit at the reported index is 0, it returns to 0.
- R8: Sub-pending register (address 5): bit 13 or 14 becomes 1 when sub_req_i at the same position is sampled high. All other bits read 0.
- R9: Source bit 9 is set only by the sub-stage. This happens when a sub-pending bit is 1 and its sub-mask bit (address 6, value 1 blocks) is 0. src_req_i[9] has no effect.
- R10: After reset, mask and sub-mask read all ones over their width, mode reads 0, and all pending and offset registers read 0.
- R11: Address 7 reads 0. Writes to the offset register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_req_i | input | 32 | Level requests from the sources |
| sub_req_i | input | 16 | Level requests from sub-sources (bits 13 and 14 used) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
Directed cases cover the following:
- A masked and an unmasked request arriving together, which separates latching from service.
- The two-step clear order, which shows the offset returning to zero only after both pending stages are empty.
- A request colliding with its own clear.
- A multi-bit mode write, which must be rejected next to a legal single-bit one.
- Sub-requests with their sub-mask set and then cleared, next to a direct pulse on the shared parent input.

Sparse random requests mixed with random writes to every address then exercise several sources pending at once. This shows the lowest-index choice, the hold of a nonempty winner register, and the fast and normal paths running side by side.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_SRC    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_WIN    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_OFF    = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_SUBPND = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_SUBMSK = 3'd6;
endpackage

// File: rtl/irq_w1c_reg.sv
module irq_w1c_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;  // set wins over clear
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N     = 32,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     oh_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  always_comb begin
    oh_o  = '0;
    idx_o = '0;
    vld_o = |req_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        oh_o     = '0;
        oh_o[i]  = 1'b1;
        idx_o    = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_sub_stage.sv
module irq_sub_stage #(
  parameter int unsigned SUB_W   = 16,
  parameter int unsigned SUB_LO  = 13,
  parameter int unsigned SUB_CNT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SUB_W-1:0] sub_req_i,
  input  logic             pnd_we_i,
  input  logic             msk_we_i,
  input  logic [SUB_W-1:0] wdata_i,
  output logic [SUB_W-1:0] pnd_o,
  output logic [SUB_W-1:0] msk_o,
  output logic             parent_req_o
);
  localparam logic [SUB_W-1:0] GRP = SUB_W'(((1 << SUB_CNT) - 1) << SUB_LO);

  logic [SUB_W-1:0] pnd_clr;
  assign pnd_clr = pnd_we_i ? wdata_i : '0;

  irq_w1c_reg #(.W(SUB_W)) u_pnd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (sub_req_i & GRP),
    .clr_i (pnd_clr),
    .q_o   (pnd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       msk_o <= '1;
    else if (msk_we_i) msk_o <= wdata_i;
  end

  assign parent_req_o = |(pnd_o & ~msk_o & GRP);
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NSRC       = 32,
  parameter int unsigned SUB_W      = 16,
  parameter int unsigned SUB_LO     = 13,
  parameter int unsigned SUB_CNT    = 2,
  parameter int unsigned SUB_PARENT = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_req_i,
  input  logic [SUB_W-1:0]  sub_req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int unsigned OFF_W = $clog2(NSRC);

  logic [NSRC-1:0]  src_pnd, mode_q, mask_q, win_q, eff_req, src_clr, cand, win_oh;
  logic [OFF_W-1:0] off_q, win_idx;
  logic             win_vld, parent_req;
  logic [SUB_W-1:0] sub_pnd, sub_msk;

  logic wr_src, wr_mode, wr_mask, wr_win, wr_subp, wr_subm;
  assign wr_src  = wr_en_i && (addr_i == ADDR_SRC);
  assign wr_mode = wr_en_i && (addr_i == ADDR_MODE);
  assign wr_mask = wr_en_i && (addr_i == ADDR_MASK);
  assign wr_win  = wr_en_i && (addr_i == ADDR_WIN);
  assign wr_subp = wr_en_i && (addr_i == ADDR_SUBPND);
  assign wr_subm = wr_en_i && (addr_i == ADDR_SUBMSK);

  irq_sub_stage #(.SUB_W(SUB_W), .SUB_LO(SUB_LO), .SUB_CNT(SUB_CNT)) u_sub (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sub_req_i   (sub_req_i),
    .pnd_we_i    (wr_subp),
    .msk_we_i    (wr_subm),
    .wdata_i     (wdata_i[SUB_W-1:0]),
    .pnd_o       (sub_pnd),
    .msk_o       (sub_msk),
    .parent_req_o(parent_req)
  );

  // parent bit is driven only by the sub-stage
  always_comb begin
    eff_req             = src_req_i;
    eff_req[SUB_PARENT] = parent_req;
  end

  assign src_clr = wr_src ? wdata_i : '0;

  irq_w1c_reg #(.W(NSRC)) u_src (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (eff_req),
    .clr_i (src_clr),
    .q_o   (src_pnd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      mask_q <= '1;
    end else begin
      if (wr_mode && ((wdata_i & (wdata_i - NSRC'(1))) == '0)) mode_q <= wdata_i;
      if (wr_mask) mask_q <= wdata_i;
    end
  end

  assign cand = src_pnd & ~mode_q & ~mask_q;

  irq_prio_enc #(.N(NSRC)) u_prio (
    .req_i(cand),
    .oh_o (win_oh),
    .idx_o(win_idx),
    .vld_o(win_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      off_q <= '0;
    end else if (win_q == '0) begin
      if (win_vld) begin
        win_q <= win_oh;
        off_q <= win_idx;
      end else if (!src_pnd[off_q]) begin
        off_q <= '0;
      end
    end else if (wr_win) begin
      win_q <= win_q & ~wdata_i;
    end
  end

  assign irq_o = |win_q;
  assign fiq_o = |(src_pnd & mode_q & ~mask_q);

  always_comb begin
    unique case (addr_i)
      ADDR_SRC:    rdata_o = src_pnd;
      ADDR_MODE:   rdata_o = mode_q;
      ADDR_MASK:   rdata_o = mask_q;
      ADDR_WIN:    rdata_o = win_q;
      ADDR_OFF:    rdata_o = NSRC'(off_q);
      ADDR_SUBPND: rdata_o = NSRC'(sub_pnd);
      ADDR_SUBMSK: rdata_o = NSRC'(sub_msk);
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk
  import irq_pkg::*;
#(
  parameter int unsigned NSRC       = 32,
  parameter int unsigned SUB_PARENT = 9,
  localparam int unsigned OFF_W     = $clog2(NSRC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NSRC-1:0]   src_req_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              fiq_o,
  input logic              irq_o,
  input logic [NSRC-1:0]   src_pnd,
  input logic [NSRC-1:0]   mode_q,
  input logic [NSRC-1:0]   mask_q,
  input logic [NSRC-1:0]   win_q,
  input logic [OFF_W-1:0]  off_q
);
  localparam logic [NSRC-1:0] PARENT_BIT = NSRC'(1) << SUB_PARENT;

  logic [NSRC-1:0] direct_req;
  logic            win_wr;
  assign direct_req = src_req_i & ~PARENT_BIT;
  assign win_wr     = wr_en_i && (addr_i == ADDR_WIN);

  assert_latch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((src_pnd & $past(direct_req)) == $past(direct_req)));

  assert_mode_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mode_q));

  assert_masked_no_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(win_q) == '0 && win_q != '0) |-> ((win_q & $past(mask_q | mode_q)) == '0));

  assert_fiq_unmasked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> ((mode_q & ~mask_q) != '0));

  assert_win_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_q));

  assert_win_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !win_wr) |=> ($stable(win_q) && irq_o));

  assert_offset_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q != '0) |-> win_q[off_q]);
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.NSRC(NSRC), .SUB_PARENT(SUB_PARENT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_req_i (src_req_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .fiq_o     (fiq_o),
  .irq_o     (irq_o),
  .src_pnd   (src_pnd),
  .mode_q    (mode_q),
  .mask_q    (mask_q),
  .win_q     (win_q),
  .off_q     (off_q)
);

// File: tb/test_irq_pend_ctrl.sv
`timescale 1ns/1ps
module test_irq_pend_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_req_i = '0;
  logic [15:0] sub_req_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        fiq_o, irq_o;

  always #2.5 clk_i = ~clk_i;

  irq_pend_ctrl i_irq_pend_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_req_i(src_req_i), .sub_req_i(sub_req_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .fiq_o(fiq_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // reference model
  logic [31:0] m_src, m_mode, m_mask, m_win;
  logic [4:0]  m_off;
  logic [15:0] m_sub, m_submsk;
  localparam logic [15:0] GRP = 16'h6000;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_src;
      3'd1: return m_mode;
      3'd2: return m_mask;
      3'd3: return m_win;
      3'd4: return {27'b0, m_off};
      3'd5: return {16'b0, m_sub};
      3'd6: return {16'b0, m_submsk};
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic m_reset();
    m_src = '0; m_mode = '0; m_mask = '1; m_win = '0; m_off = '0;
    m_sub = '0; m_submsk = '1;
  endtask

  task automatic m_update(input logic [31:0] req, input logic [15:0] sreq,
                          input logic we, input logic [2:0] a, input logic [31:0] wd);
    logic [31:0] eff, cand, n_src, n_mode, n_mask, n_win;
    logic [15:0] n_sub, n_submsk;
    logic [4:0]  n_off;
    eff    = req;
    eff[9] = |(m_sub & ~m_submsk & GRP);
    n_src  = (m_src & ~((we && a == 3'd0) ? wd : 32'h0)) | eff;
    n_sub  = (m_sub & ~((we && a == 3'd5) ? wd[15:0] : 16'h0)) | (sreq & GRP);
    n_mode = (we && a == 3'd1 && ((wd & (wd - 1)) == 0)) ? wd : m_mode;
    n_mask = (we && a == 3'd2) ? wd : m_mask;
    n_submsk = (we && a == 3'd6) ? wd[15:0] : m_submsk;
    n_win = m_win;
    n_off = m_off;
    cand = m_src & ~m_mode & ~m_mask;
    if (m_win == 0) begin
      if (cand != 0) begin
        for (int i = 31; i >= 0; i--)
          if (cand[i]) begin n_win = 32'h1 << i; n_off = 5'(i); end
      end else if (!m_src[m_off]) n_off = '0;
    end else if (we && a == 3'd3) n_win = m_win & ~wd;
    m_src = n_src; m_sub = n_sub; m_mode = n_mode; m_mask = n_mask;
    m_submsk = n_submsk; m_win = n_win; m_off = n_off;
  endtask

  // one cycle; entered and left at a falling edge
  task automatic cyc(input logic [31:0] req, input logic [15:0] sreq,
                     input logic we, input logic [2:0] a, input logic [31:0] wd);
    src_req_i = req; sub_req_i = sreq; wr_en_i = we; addr_i = a; wdata_i = wd;
    #1;
    if (!we) chk(rdata_o, m_read(a), tag_of(a));
    @(posedge clk_i);
    m_update(req, sreq, we, a, wd);
    @(negedge clk_i);
    chk({31'b0, irq_o}, {31'b0, |m_win}, "R6");
    chk({31'b0, fiq_o}, {31'b0, |(m_src & m_mode & ~m_mask)}, "R5");
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    src_req_i = '0; sub_req_i = '0; wr_en_i = 1'b0; addr_i = a;
    #1;
    chk(rdata_o, exp, tag);
    @(negedge clk_i);
    m_update('0, '0, 1'b0, a, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, '0, 1'b0, 3'd0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r, wd;
    logic [2:0]  a;
    void'($urandom(32'd2024));
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 reset values
    rd(3'd2, 32'hFFFF_FFFF, "R10");
    rd(3'd6, 32'h0000_FFFF, "R10");
    rd(3'd1, 32'h0, "R10");
    rd(3'd0, 32'h0, "R10");
    rd(3'd3, 32'h0, "R10");
    rd(3'd4, 32'h0, "R10");

    // R1 R4 R6 R7: unmask 5, request 5 and masked 3 together
    cyc('0, '0, 1'b1, 3'd2, ~(32'h1 << 5));
    cyc((32'h1 << 5) | (32'h1 << 3), '0, 1'b0, 3'd0, '0);
    idle(2);
    rd(3'd0, (32'h1 << 5) | (32'h1 << 3), "R1");
    rd(3'd3, 32'h1 << 5, "R4");
    rd(3'd4, 32'd5, "R7");
    chk({31'b0, irq_o}, 32'h1, "R6");

    // R6 hold: unmask 2 (lower index), winner stays 5
    cyc((32'h1 << 2), '0, 1'b1, 3'd2, ~((32'h1 << 5) | (32'h1 << 2)));
    idle(2);
    rd(3'd3, 32'h1 << 5, "R6");

    // R2 R7 clear order: source then winner; 2 wins next
    cyc('0, '0, 1'b1, 3'd0, 32'h1 << 5);
    cyc('0, '0, 1'b1, 3'd3, 32'h1 << 5);
    idle(2);
    rd(3'd4, 32'd2, "R7");
    cyc('0, '0, 1'b1, 3'd0, 32'h1 << 2);
    cyc('0, '0, 1'b1, 3'd3, 32'h1 << 2);
    idle(2);
    rd(3'd4, 32'd0, "R7");
    chk({31'b0, irq_o}, 32'h0, "R6");
    rd(3'd0, 32'h1 << 3, "R2");

    // R2 request wins over clear; writing 0 keeps bits
    cyc(32'h1 << 7, '0, 1'b0, 3'd0, '0);
    cyc(32'h1 << 7, '0, 1'b1, 3'd0, 32'h1 << 7);
    rd(3'd0, (32'h1 << 7) | (32'h1 << 3), "R2");
    cyc('0, '0, 1'b1, 3'd0, 32'h0);
    rd(3'd0, (32'h1 << 7) | (32'h1 << 3), "R2");

    // R3 R5: multi-bit mode write rejected, single-bit accepted
    cyc('0, '0, 1'b1, 3'd1, 32'h0000_0180);
    rd(3'd1, 32'h0, "R3");
    cyc('0, '0, 1'b1, 3'd1, 32'h1 << 7);
    rd(3'd1, 32'h1 << 7, "R3");
    cyc('0, '0, 1'b1, 3'd2, ~(32'h1 << 7));
    idle(1);
    chk({31'b0, fiq_o}, 32'h1, "R5");
    chk({31'b0, irq_o}, 32'h0, "R5");

    // R11: offset write ignored, address 7 reads 0
    cyc('0, '0, 1'b1, 3'd4, 32'h1F);
    rd(3'd4, 32'h0, "R11");
    rd(3'd7, 32'h0, "R11");

    // R9: direct pulse on bit 9 ignored
    cyc(32'h1 << 9, '0, 1'b0, 3'd0, '0);
    idle(1);
    chk((rdata_o >> 9) & 32'h1, 32'h0, "R9");

    // R8: sub bit 13 latches, sub bit 0 does not
    cyc('0, 16'h2001, 1'b0, 3'd0, '0);
    idle(1);
    rd(3'd5, 32'h2000, "R8");
    rd(3'd0, (32'h1 << 7) | (32'h1 << 3), "R9");
    // R9: unmask sub 13 -> parent bit 9 sets
    cyc('0, '0, 1'b1, 3'd6, 32'h0000_DFFF);
    idle(2);
    rd(3'd0, (32'h1 << 9) | (32'h1 << 7) | (32'h1 << 3), "R9");
    cyc('0, '0, 1'b1, 3'd5, 32'h2000);
    rd(3'd5, 32'h0, "R8");

    // random phase
    for (int k = 0; k < 4000; k++) begin
      r  = $urandom & $urandom & $urandom & $urandom;
      a  = 3'($urandom % 8);
      wd = $urandom;
      if (a == 3'd1 && wd[0]) wd = 32'h1 << ($urandom % 32);
      else if (a == 3'd2 || a == 3'd6) wd = $urandom | $urandom;
      cyc(r, 16'($urandom & $urandom & $urandom), ($urandom % 4) == 0, a, wd);
    end

    finish_run();
  end
endmodule